// File: doc/BRIEF.md
# Byte Permute and Merge Unit

This datapath rearranges bytes for a 64-bit SIMD pipeline. Each request carries two 64-bit operands, a 2-bit operation code and a 32-bit byte-selection mask. The mask is the upper half of a status register, and the pipeline delivers it alongside the operands. Three operations are available:

- **Shuffle.** Picks each result byte from a 16-byte pool formed by the two operands.
- **Merge.** Interleaves the low four bytes of each operand.
- **Expand.** Widens the low four bytes of the first operand into four 16-bit lanes, each byte scaled up by four bit positions.

Requests enter on a valid/ready handshake and results leave on another. With the default output register, a result is presented one cycle after its request is accepted. It is held unchanged while the consumer withholds ready. The unit accepts a new request in the same cycle the held result drains, so back-pressure costs no bubble. With the register disabled by parameter, the unit is a pure combinational path and the handshake passes straight through.

Top module: `bpm_unit`

## Requirements
- R1: For `op` = 0 (shuffle), result byte i (byte 0 = bits [7:0]) is selected by mask nibble `sel_mask[31-4i:28-4i]`. The 16-byte pool is indexed with index 0 = `src_a[63:56]`, index 7 = `src_a[7:0]`, index 8 = `src_b[63:56]` and index 15 = `src_b[7:0]`.
- R2: The shuffle mask 0x01234567 yields `src_a` with its byte order reversed. Result bits [7:0] equal `src_a[63:56]`.
- R3: For `op` = 1 (merge), for k = 0..3, result byte 2k+1 is `src_a` byte k and result byte 2k is `src_b` byte k. Bits [63:32] of both operands have no effect.
- R4: For `op` = 2 (expand), the 16-bit lane j (bits [16j+15:16j]) equals `src_a` byte j shifted left by 4, with all other lane bits zero. `src_b` and `src_a[63:32]` have no effect.
- R5: For `op` = 3 the result is all zeros.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` stays constant and `in_ready` is low.
- R7: A request transfers when `in_valid` and `in_ready` are both high. `out_valid` is high in the following cycle. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R8: After reset, `out_valid` is low, `out_data` is zero and `in_ready` is high.
- R9: The operands, operation and mask are captured at the transfer. Changing them afterwards does not alter a held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 2 | Operation: 0 shuffle, 1 merge, 2 expand, 3 zero |
| in_src_a | input | 64 | First operand |
| in_src_b | input | 64 | Second operand |
| sel_mask | input | 32 | Shuffle mask, eight 4-bit indices |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Result |

## Verification
A wrong pool index or lane placement in the combinational selectors appears on `out_data` in the cycle after the request is accepted. Known byte patterns and a broadcast mask make each misrouted byte identifiable by value. A faulty output register shows up during a stall: the result drifts, or `in_ready` stays high while data is held. Capturing the wrong operand shows up when the inputs change during that stall. Both effects are visible within the stalled cycles, before the consumer resumes.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  // Operation codes carried on in_op
  typedef enum logic [1:0] {
    OP_SHUF   = 2'd0,
    OP_MERGE  = 2'd1,
    OP_EXPAND = 2'd2,
    OP_ZERO   = 2'd3
  } bpm_op_e;

  localparam int BYTE_W = 8;
  localparam int LANE_W = 16;

endpackage

// File: rtl/bpm_shuffle.sv
// Mask-driven byte selection over the concatenation of two operands.
module bpm_shuffle #(
  parameter int DATA_W = 64,
  localparam int NB     = DATA_W / bpm_pkg::BYTE_W,
  localparam int POOL   = 2 * NB,
  localparam int IW     = $clog2(POOL),
  localparam int MASK_W = NB * IW
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [MASK_W-1:0] mask,
  output logic [DATA_W-1:0] result
);
  localparam int BW = bpm_pkg::BYTE_W;

  logic [2*DATA_W-1:0] pool;
  assign pool = {src_a, src_b};

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [IW-1:0] idx;
    logic [BW-1:0] pick;
    // result byte 0 takes the most significant index field
    assign idx = mask[MASK_W-1-IW*i -: IW];
    always_comb begin
      pick = '0;
      for (int e = 0; e < POOL; e++) begin
        if (idx == IW'(e)) pick = pool[(POOL-1-e)*BW +: BW];
      end
    end
    assign result[i*BW +: BW] = pick;
  end
endmodule

// File: rtl/bpm_merge.sv
// Byte interleave of the low halves of two operands.
module bpm_merge #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int HB     = HALF_W / bpm_pkg::BYTE_W
) (
  input  logic [HALF_W-1:0] lo_a,
  input  logic [HALF_W-1:0] lo_b,
  output logic [DATA_W-1:0] result
);
  localparam int BW = bpm_pkg::BYTE_W;

  for (genvar k = 0; k < HB; k++) begin : g_pair
    assign result[(2*k+1)*BW +: BW] = lo_a[k*BW +: BW];
    assign result[(2*k)*BW   +: BW] = lo_b[k*BW +: BW];
  end
endmodule

// File: rtl/bpm_expand.sv
// Widens each low byte into a 16-bit lane with a fixed left shift.
module bpm_expand #(
  parameter int DATA_W = 64,
  parameter int SHIFT  = 4,
  localparam int HALF_W = DATA_W / 2,
  localparam int LANES  = DATA_W / bpm_pkg::LANE_W
) (
  input  logic [HALF_W-1:0] lo_a,
  output logic [DATA_W-1:0] result
);
  localparam int BW = bpm_pkg::BYTE_W;
  localparam int LW = bpm_pkg::LANE_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign result[j*LW +: LW] = LW'(lo_a[j*BW +: BW]) << SHIFT;
  end
endmodule

// File: rtl/bpm_unit.sv
module bpm_unit #(
  parameter int  DATA_W    = 64,
  parameter bit  REG_OUT   = 1'b1,
  parameter int  EXP_SHIFT = 4,
  localparam int NB        = DATA_W / bpm_pkg::BYTE_W,
  localparam int MASK_W    = NB * $clog2(2 * NB),
  localparam int HALF_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [MASK_W-1:0] sel_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import bpm_pkg::*;

  logic [DATA_W-1:0] shuf_res, merge_res, exp_res, comb_res;
  bpm_op_e op;
  assign op = bpm_op_e'(in_op);

  bpm_shuffle #(.DATA_W(DATA_W)) u_shuf (
    .src_a (in_src_a),
    .src_b (in_src_b),
    .mask  (sel_mask),
    .result(shuf_res)
  );

  bpm_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_a  (in_src_a[HALF_W-1:0]),
    .lo_b  (in_src_b[HALF_W-1:0]),
    .result(merge_res)
  );

  bpm_expand #(.DATA_W(DATA_W), .SHIFT(EXP_SHIFT)) u_exp (
    .lo_a  (in_src_a[HALF_W-1:0]),
    .result(exp_res)
  );

  always_comb begin
    unique case (op)
      OP_SHUF:   comb_res = shuf_res;
      OP_MERGE:  comb_res = merge_res;
      OP_EXPAND: comb_res = exp_res;
      default:   comb_res = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;
    assign in_ready = !vld_q || out_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_valid && in_ready) begin
        vld_q <= 1'b1;
        dat_q <= comb_res;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = comb_res;
  end
endmodule

// File: rtl/bpm_unit_chk.sv
module bpm_unit_chk #(
  parameter int  DATA_W    = 64,
  parameter bit  REG_OUT   = 1'b1,
  parameter int  EXP_SHIFT = 4,
  localparam int NB        = DATA_W / 8,
  localparam int MASK_W    = NB * $clog2(2 * NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_src_a,
  input logic [DATA_W-1:0] in_src_b,
  input logic [MASK_W-1:0] sel_mask,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  localparam logic [15:0]       LPAD = ~(16'h00FF << EXP_SHIFT);
  localparam logic [DATA_W-1:0] PAD  = {(DATA_W/16){LPAD}};

  logic xfer;
  assign xfer = in_valid && in_ready;

  if (REG_OUT) begin : g_seq
    assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> out_valid);
    assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
    assert_zero_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && in_op == 2'd3) |=> out_data == '0);
    assert_expand_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && in_op == 2'd2) |=> (out_data & PAD) == '0);
    assert_merge_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && in_op == 2'd1) |=>
        out_data[15:0] == {$past(in_src_a[7:0]), $past(in_src_b[7:0])});
  end else begin : g_cmb
    always_comb begin
      if (in_op == 2'd3) assert_zero_op_comb_R5: assert (out_data == '0);
    end
  end
endmodule

bind bpm_unit bpm_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT), .EXP_SHIFT(EXP_SHIFT)) u_chk (.*);

// File: tb/tb_bpm_unit.sv
`timescale 1ns/1ps
module tb_bpm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [1:0]  in_op;
  logic [63:0] in_src_a, in_src_b, out_data;
  logic [31:0] sel_mask;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bpm_unit dut (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] m;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] VA = 64'h0011223344556677;
  localparam logic [63:0] VB = 64'h8899AABBCCDDEEFF;
  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{2'd0, VA, VB, 32'h01234567, 64'h7766554433221100, 8'd2}, // R2 reversed src_a
    '{2'd0, VA, VB, 32'h89ABCDEF, 64'hFFEEDDCCBBAA9988, 8'd1}, // R1 src_b pool half
    '{2'd0, VA, VB, 32'h33333333, 64'h3333333333333333, 8'd1}, // R1 broadcast
    '{2'd0, VA, VB, 32'hF0F0F0F0, 64'h00FF00FF00FF00FF, 8'd1}, // R1 pool ends
    '{2'd1, VA, VB, 32'h0,        64'h44CC55DD66EE77FF, 8'd3}, // R3 merge
    '{2'd2, VA, VB, 32'h0,        64'h0440055006600770, 8'd4}, // R4 expand
    '{2'd3, VA, VB, 32'h12345678, 64'h0,                8'd5}  // R5 zero op
  };

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [31:0] m);
    logic [127:0] pool;
    logic [63:0]  r;
    pool = {a, b};
    r = '0;
    case (op)
      2'd0: for (int i = 0; i < 8; i++) begin
        int idx;
        idx = int'(m[31-4*i -: 4]);
        r[8*i +: 8] = pool[(15-idx)*8 +: 8];
      end
      2'd1: for (int k = 0; k < 4; k++) begin
        r[8*(2*k+1) +: 8] = a[8*k +: 8];
        r[8*(2*k) +: 8]   = b[8*k +: 8];
      end
      2'd2: for (int j = 0; j < 4; j++) r[16*j +: 16] = {4'h0, a[8*j +: 8], 4'h0};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [31:0] m, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_op = op; in_src_a = a; in_src_b = b; sel_mask = m;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " valid (R7)"}, {63'd0, out_valid}, 64'd1);
    chk(out_data == exp, tag, out_data, exp);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] hold;
    logic [63:0] a2, b2, e2;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_src_a = '0; in_src_b = '0; sel_mask = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid", {63'd0, out_valid}, 64'd0);
    chk(out_data == '0, "R8 out_data", out_data, 64'd0);
    chk(in_ready == 1'b1, "R8 in_ready", {63'd0, in_ready}, 64'd1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VT[v].req, v);
      run_op(VT[v].op, VT[v].a, VT[v].b, VT[v].m, VT[v].exp, t);
    end

    // Random against model (R1 shuffle, R3 merge, R4 expand)
    for (int n = 0; n < 40; n++) begin
      logic [1:0]  op;
      logic [63:0] a, b;
      logic [31:0] m;
      op = 2'(n % 4);
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      m = $urandom();
      run_op(op, a, b, m, model(op, a, b, m), $sformatf("R1/R3/R4 random op%0d", op));
    end

    // R6/R9: stall holds the result while inputs change
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 2'd0; in_src_a = VA; in_src_b = VB; sel_mask = 32'h01234567;
    in_valid = 1'b1;
    @(negedge clk);
    hold = 64'h7766554433221100;
    a2 = 64'h0102030405060708; b2 = 64'h1112131415161718;
    in_src_a = a2; in_src_b = b2; sel_mask = 32'hFEDCBA98; in_op = 2'd0;
    e2 = model(2'd0, a2, b2, 32'hFEDCBA98);
    chk(in_ready == 1'b0, "R6 in_ready low in stall", {63'd0, in_ready}, 64'd0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(out_valid && out_data == hold, "R6 R9 held result", out_data, hold);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == e2, "R7 accept on drain", out_data, e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained", {63'd0, out_valid}, 64'd0);

    // R5 zero op with nonzero operands following a nonzero result
    run_op(2'd0, VA, VB, 32'h77777777, 64'h7777777777777777, "R1 broadcast idx7");
    run_op(2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 32'hFFFFFFFF, 64'h0, "R5 zero");
    // R4 upper operand bits ignored
    run_op(2'd2, 64'hDEADBEEF000000FF, 64'hFFFFFFFFFFFFFFFF, 32'h0, 64'h0000000000000FF0,
           "R4 ignore upper");
    // R3 upper halves ignored
    run_op(2'd1, 64'hFFFFFFFF00000000, 64'hFFFFFFFF00000000, 32'h0, 64'h0, "R3 ignore upper");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule